// File: doc/BRIEF.md
# Cross-Domain Mailbox Register Pair

The block holds two command registers that pass short control words between two ports running on unrelated clocks. These words do not go through the data queue. The first register carries a word from port A to port B, and the second carries a word from port B to port A. Each register has an active-low full flag. The flag drops when the writer stores a word. It rises again only after the other port has read the word and that read has been carried back into the writer's clock domain. While the flag is low, the register cannot be overwritten.

Each port has a select, a direction, an enable and a mailbox-select input. On a read, the port's data output shows either the mailbox that port receives or the output register of the queue that sits beside the block. The mailbox-select input chooses between them. The port-B bus size (full, half or quarter width) sets how many low-order bits of a mailbox word are kept. Bits above the configured width are stored as zero.

A full-flag change crosses domains through a toggle handshake with two-stage synchronizers in each direction. A writer therefore sees its flag rise a fixed few cycles of its own clock after the reader has consumed the word.

Top module: `xdom_mailbox`

## Requirements
- R1: While `rstN` is low, and after it is released, both full flags are high and both mailbox registers hold zero.
- R2: Mailbox 1 stores `aDin` on a rising `clkA` edge when `aSel`, `aWrite`, `aEn` and `aMbx` are all high and `mail1FullN` is high.
- R3: Mailbox 2 stores `bDin` on a rising `clkB` edge when `bSel`, `bWrite`, `bEn` and `bMbx` are all high and `mail2FullN` is high.
- R4: The full flag of a mailbox goes low immediately after the writer's clock edge that stores a word.
- R5: A write attempt made while the mailbox's full flag is low leaves the stored word unchanged.
- R6: A port-B mailbox read sets `mail1FullN` high again. Such a read is a rising `clkB` edge with `bSel`, `bEn` and `bMbx` high and `bWrite` low, made once the stored word has reached the `clkB` domain. The flag is still low just after that read edge and is high within four `clkA` cycles.
- R7: A port-A mailbox read sets `mail2FullN` high again in the same way. Such a read is a rising `clkA` edge with `aSel`, `aEn` and `aMbx` high and `aWrite` low. The flag is high within four `clkB` cycles.
- R8: A read with the mailbox select low, or with the enable low, leaves the full flag low.
- R9: `busSize` encodes the width as 2'b00 = 36 bits, 2'b01 = 18 bits, 2'b10 = 9 bits, and 2'b11 = 36 bits. Only the low 36, 18 or 9 bits of a written word are kept, and the rest are stored as zero. This applies to both mailboxes.
- R10: A port's output is active when its select is high and its direction is low (read). When active, the output shows that port's incoming mailbox if mailbox-select is high (A shows mailbox 2, B shows mailbox 1), and the queue output input (`fifoOutA`/`fifoOutB`) if it is low. When inactive, the output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| busSize | input | 2 | Port-B bus width code |
| aSel | input | 1 | Port A select |
| aWrite | input | 1 | Port A direction, 1 = write |
| aEn | input | 1 | Port A transfer enable |
| aMbx | input | 1 | Port A mailbox select |
| aDin | input | 36 | Port A write data |
| fifoOutA | input | 36 | Queue output register seen by port A |
| aDout | output | 36 | Port A read data |
| bSel | input | 1 | Port B select |
| bWrite | input | 1 | Port B direction, 1 = write |
| bEn | input | 1 | Port B transfer enable |
| bMbx | input | 1 | Port B mailbox select |
| bDin | input | 36 | Port B write data |
| fifoOutB | input | 36 | Queue output register seen by port B |
| bDout | output | 36 | Port B read data |
| mail1FullN | output | 1 | Mailbox 1 full flag, active low, clkA domain |
| mail2FullN | output | 1 | Mailbox 2 full flag, active low, clkB domain |

## Verification
The bench sweeps every bus-size code over a set of data patterns in both directions. It checks the word each reader sees against the written word masked by that width. A design that kept stale upper bits, or masked at the wrong width, fails these checks. Overwrite attempts while a flag is low, and reads with the mailbox select or the enable low, are each followed by a read of the stored word or a look at the flag. This exposes a register that gets clobbered or a flag that is released by the wrong kind of read. The flag is sampled just after the releasing read and again a few writer cycles later. A flag that skips the synchronizer, or never returns high, shows up there.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    SIZE_FULL    = 2'b00,
    SIZE_HALF    = 2'b01,
    SIZE_QUARTER = 2'b10,
    SIZE_SPARE   = 2'b11
  } bus_size_e;

  typedef struct packed {
    logic load1;  // clkA domain: capture port A word into mailbox 1
    logic load2;  // clkB domain: capture port B word into mailbox 2
  } mbx_strobe_t;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_chan_ctrl.sv
module mbx_chan_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic wClk,
  input  logic rClk,
  input  logic rstN,
  input  logic wrAttempt,
  input  logic rdAttempt,
  output logic load,
  output logic fullN
);
  logic reqTog;
  logic ackTog;
  logic reqSeen;
  logic ackSeen;
  logic avail;

  // writer domain: a stored word flips the request toggle
  assign fullN = (reqTog == ackSeen);
  assign load  = wrAttempt & fullN;

  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN)     reqTog <= 1'b0;
    else if (load) reqTog <= ~reqTog;
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) uReqSync (
    .clk(rClk), .rstN(rstN), .d(reqTog), .q(reqSeen)
  );

  // reader domain: a word is available once the request has arrived
  assign avail = reqSeen ^ ackTog;

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN)                  ackTog <= 1'b0;
    else if (rdAttempt && avail) ackTog <= ~ackTog;
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) uAckSync (
    .clk(wClk), .rstN(rstN), .d(ackTog), .q(ackSeen)
  );
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clkA,
  input  logic        clkB,
  input  logic        rstN,
  input  logic        aSel,
  input  logic        aWrite,
  input  logic        aEn,
  input  logic        aMbx,
  input  logic        bSel,
  input  logic        bWrite,
  input  logic        bEn,
  input  logic        bMbx,
  output mbx_strobe_t strobe,
  output logic        mail1FullN,
  output logic        mail2FullN
);
  logic aMbxWr, aMbxRd, bMbxWr, bMbxRd;

  assign aMbxWr = aSel & aEn & aMbx &  aWrite;
  assign aMbxRd = aSel & aEn & aMbx & ~aWrite;
  assign bMbxWr = bSel & bEn & bMbx &  bWrite;
  assign bMbxRd = bSel & bEn & bMbx & ~bWrite;

  // mailbox 1: written by A, consumed by B
  mbx_chan_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uChan1 (
    .wClk(clkA), .rClk(clkB), .rstN(rstN),
    .wrAttempt(aMbxWr), .rdAttempt(bMbxRd),
    .load(strobe.load1), .fullN(mail1FullN)
  );

  // mailbox 2: written by B, consumed by A
  mbx_chan_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uChan2 (
    .wClk(clkB), .rClk(clkA), .rstN(rstN),
    .wrAttempt(bMbxWr), .rdAttempt(aMbxRd),
    .load(strobe.load2), .fullN(mail2FullN)
  );
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clkA,
  input  logic         clkB,
  input  logic         rstN,
  input  mbx_strobe_t  strobe,
  input  logic [1:0]   busSize,
  input  logic [W-1:0] aDin,
  input  logic [W-1:0] bDin,
  input  logic         aSel,
  input  logic         aWrite,
  input  logic         aMbx,
  input  logic [W-1:0] fifoOutA,
  input  logic         bSel,
  input  logic         bWrite,
  input  logic         bMbx,
  input  logic [W-1:0] fifoOutB,
  output logic [W-1:0] aDout,
  output logic [W-1:0] bDout
);
  localparam int HALF_W    = W / 2;
  localparam int QUARTER_W = W / 4;
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] keepMask;
  logic [W-1:0] mail1Q;
  logic [W-1:0] mail2Q;

  always_comb begin
    unique case (bus_size_e'(busSize))
      SIZE_HALF:    keepMask = ALL_ONES >> (W - HALF_W);
      SIZE_QUARTER: keepMask = ALL_ONES >> (W - QUARTER_W);
      default:      keepMask = ALL_ONES;
    endcase
  end

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)              mail1Q <= '0;
    else if (strobe.load1)  mail1Q <= aDin & keepMask;
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)              mail2Q <= '0;
    else if (strobe.load2)  mail2Q <= bDin & keepMask;
  end

  always_comb begin
    aDout = '0;
    if (aSel && !aWrite) aDout = aMbx ? mail2Q : fifoOutA;
  end

  always_comb begin
    bDout = '0;
    if (bSel && !bWrite) bDout = bMbx ? mail1Q : fifoOutB;
  end
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox
  import mbx_pkg::*;
#(
  parameter int W           = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clkA,
  input  logic         clkB,
  input  logic         rstN,
  input  logic [1:0]   busSize,
  input  logic         aSel,
  input  logic         aWrite,
  input  logic         aEn,
  input  logic         aMbx,
  input  logic [W-1:0] aDin,
  input  logic [W-1:0] fifoOutA,
  output logic [W-1:0] aDout,
  input  logic         bSel,
  input  logic         bWrite,
  input  logic         bEn,
  input  logic         bMbx,
  input  logic [W-1:0] bDin,
  input  logic [W-1:0] fifoOutB,
  output logic [W-1:0] bDout,
  output logic         mail1FullN,
  output logic         mail2FullN
);
  mbx_strobe_t strobe;

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aSel(aSel), .aWrite(aWrite), .aEn(aEn), .aMbx(aMbx),
    .bSel(bSel), .bWrite(bWrite), .bEn(bEn), .bMbx(bMbx),
    .strobe(strobe), .mail1FullN(mail1FullN), .mail2FullN(mail2FullN)
  );

  mbx_datapath #(.W(W)) u_dp (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .strobe(strobe), .busSize(busSize),
    .aDin(aDin), .bDin(bDin),
    .aSel(aSel), .aWrite(aWrite), .aMbx(aMbx), .fifoOutA(fifoOutA),
    .bSel(bSel), .bWrite(bWrite), .bMbx(bMbx), .fifoOutB(fifoOutB),
    .aDout(aDout), .bDout(bDout)
  );
endmodule

// File: rtl/xdom_mailbox_checker.sv
module xdom_mailbox_checker #(
  parameter int W = 36
) (
  input logic         clkA,
  input logic         clkB,
  input logic         rstN,
  input logic [1:0]   busSize,
  input logic         aSel, aWrite, aEn, aMbx,
  input logic         bSel, bWrite, bEn, bMbx,
  input logic         mail1FullN,
  input logic         mail2FullN,
  input logic         load1,
  input logic         load2,
  input logic [W-1:0] mail1Q,
  input logic [W-1:0] mail2Q
);
  localparam int QUARTER_W = W / 4;

  assert_flag1_drops_R4: assert property (@(posedge clkA) disable iff (!rstN)
    (aSel && aWrite && aEn && aMbx && mail1FullN) |=> !mail1FullN);

  assert_flag2_drops_R4: assert property (@(posedge clkB) disable iff (!rstN)
    (bSel && bWrite && bEn && bMbx && mail2FullN) |=> !mail2FullN);

  assert_mail1_held_R5: assert property (@(posedge clkA) disable iff (!rstN)
    !mail1FullN |=> $stable(mail1Q));

  assert_mail2_held_R5: assert property (@(posedge clkB) disable iff (!rstN)
    !mail2FullN |=> $stable(mail2Q));

  assert_mail1_narrow_R9: assert property (@(posedge clkA) disable iff (!rstN)
    (load1 && busSize == 2'b10) |=> (mail1Q[W-1:QUARTER_W] == '0));

  assert_mail2_narrow_R9: assert property (@(posedge clkB) disable iff (!rstN)
    (load2 && busSize == 2'b10) |=> (mail2Q[W-1:QUARTER_W] == '0));
endmodule

bind xdom_mailbox xdom_mailbox_checker #(.W(W)) u_chk (
  .clkA(clkA), .clkB(clkB), .rstN(rstN), .busSize(busSize),
  .aSel(aSel), .aWrite(aWrite), .aEn(aEn), .aMbx(aMbx),
  .bSel(bSel), .bWrite(bWrite), .bEn(bEn), .bMbx(bMbx),
  .mail1FullN(mail1FullN), .mail2FullN(mail2FullN),
  .load1(strobe.load1), .load2(strobe.load2),
  .mail1Q(u_dp.mail1Q), .mail2Q(u_dp.mail2Q)
);

// File: tb/xdom_mailbox_bench.sv
module xdom_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLKB_PERIOD = 15;

  logic clkA = 1'b0, clkB = 1'b0, rstN;
  logic [1:0] busSize;
  logic aSel, aWrite, aEn, aMbx, bSel, bWrite, bEn, bMbx;
  logic [35:0] aDin, bDin, fifoOutA, fifoOutB, aDout, bDout;
  logic mail1FullN, mail2FullN;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clkA = ~clkA;
  always #(CLKB_PERIOD/2.0) clkB = ~clkB;

  xdom_mailbox u_xdom_mailbox (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .busSize(busSize),
    .aSel(aSel), .aWrite(aWrite), .aEn(aEn), .aMbx(aMbx),
    .aDin(aDin), .fifoOutA(fifoOutA), .aDout(aDout),
    .bSel(bSel), .bWrite(bWrite), .bEn(bEn), .bMbx(bMbx),
    .bDin(bDin), .fifoOutB(fifoOutB), .bDout(bDout),
    .mail1FullN(mail1FullN), .mail2FullN(mail2FullN)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] masked(input logic [1:0] sz, input logic [35:0] d);
    case (sz)
      2'b01:   return d & ((36'd1 << 18) - 1);
      2'b10:   return d & ((36'd1 << 9) - 1);
      default: return d;
    endcase
  endfunction

  task automatic idleA(); aSel = 0; aWrite = 0; aEn = 0; aMbx = 0; endtask
  task automatic idleB(); bSel = 0; bWrite = 0; bEn = 0; bMbx = 0; endtask

  task automatic writeA(input logic [35:0] d, input logic en);
    @(negedge clkA); aSel = 1; aWrite = 1; aEn = en; aMbx = 1; aDin = d;
    @(negedge clkA); idleA();
  endtask

  task automatic writeB(input logic [35:0] d, input logic en);
    @(negedge clkB); bSel = 1; bWrite = 1; bEn = en; bMbx = 1; bDin = d;
    @(negedge clkB); idleB();
  endtask

  // show mailbox 1 on port B, compare, then pulse the read with the given selects
  task automatic readB(input logic [35:0] exp, input logic mbx, input logic en, input string req);
    @(negedge clkB); bSel = 1; bWrite = 0; bMbx = 1; bEn = 0;
    #1 check(req, bDout, exp);
    bMbx = mbx; bEn = en;
    @(negedge clkB); idleB();
  endtask

  task automatic readA(input logic [35:0] exp, input logic mbx, input logic en, input string req);
    @(negedge clkA); aSel = 1; aWrite = 0; aMbx = 1; aEn = 0;
    #1 check(req, aDout, exp);
    aMbx = mbx; aEn = en;
    @(negedge clkA); idleA();
  endtask

  initial begin
    rstN = 0; busSize = 2'b00; idleA(); idleB();
    aDin = '0; bDin = '0; fifoOutA = '0; fifoOutB = '0;
    repeat (3) @(negedge clkB);
    // R1: flags high and registers zero during reset
    check("R1 flag1 in reset", {35'd0, mail1FullN}, 36'd1);
    check("R1 flag2 in reset", {35'd0, mail2FullN}, 36'd1);
    rstN = 1;
    repeat (2) @(negedge clkB);
    readB(36'd0, 1'b0, 1'b0, "R1 mailbox1 zero");
    readA(36'd0, 1'b0, 1'b0, "R1 mailbox2 zero");

    // R10: output multiplexing
    fifoOutA = 36'h123456789; fifoOutB = 36'hFEDCBA987;
    @(negedge clkA); aSel = 1; aWrite = 0; aMbx = 0; #1 check("R10 A fifo path", aDout, 36'h123456789);
    aSel = 0; #1 check("R10 A inactive", aDout, 36'd0);
    aSel = 1; aWrite = 1; #1 check("R10 A write inactive", aDout, 36'd0);
    idleA();
    @(negedge clkB); bSel = 1; bWrite = 0; bMbx = 0; #1 check("R10 B fifo path", bDout, 36'hFEDCBA987);
    bSel = 0; #1 check("R10 B inactive", bDout, 36'd0);
    idleB();

    // sweep bus size codes and patterns in both directions (R2 R3 R4 R6 R7 R9)
    for (int sz = 0; sz < 4; sz++) begin
      busSize = sz[1:0];
      for (int p = 0; p < 4; p++) begin
        logic [35:0] d1, d2;
        d1 = (p == 0) ? 36'hFFFFFFFFF : (p == 1) ? 36'hA5A5A5A5A :
             (p == 2) ? 36'h800000101 : (36'h13579BDF1 ^ (36'(sz) << 20));
        d2 = ~d1;
        writeA(d1, 1'b1);
        check("R4 flag1 low after write", {35'd0, mail1FullN}, 36'd0);
        repeat (4) @(negedge clkB);
        readB(masked(busSize, d1), 1'b1, 1'b1, "R2 R9 mailbox1 data");
        check("R6 flag1 low just after read", {35'd0, mail1FullN}, 36'd0);
        repeat (4) @(negedge clkA);
        check("R6 flag1 released", {35'd0, mail1FullN}, 36'd1);

        writeB(d2, 1'b1);
        check("R4 flag2 low after write", {35'd0, mail2FullN}, 36'd0);
        repeat (4) @(negedge clkA);
        readA(masked(busSize, d2), 1'b1, 1'b1, "R3 R9 mailbox2 data");
        check("R7 flag2 low just after read", {35'd0, mail2FullN}, 36'd0);
        repeat (4) @(negedge clkB);
        check("R7 flag2 released", {35'd0, mail2FullN}, 36'd1);
      end
    end

    busSize = 2'b00;
    // R2: write with enable low is not a write
    writeA(36'h0DEADBEEF, 1'b0);
    check("R2 no write without enable", {35'd0, mail1FullN}, 36'd1);
    // R5 + R8 on mailbox 1
    writeA(36'h111111111, 1'b1);
    writeA(36'h222222222, 1'b1);
    repeat (4) @(negedge clkB);
    readB(36'h111111111, 1'b0, 1'b1, "R5 mailbox1 kept, R8 fifo read");
    repeat (6) @(negedge clkA);
    check("R8 flag1 kept by fifo read", {35'd0, mail1FullN}, 36'd0);
    readB(36'h111111111, 1'b1, 1'b0, "R5 mailbox1 kept, R8 no enable");
    repeat (6) @(negedge clkA);
    check("R8 flag1 kept without enable", {35'd0, mail1FullN}, 36'd0);
    readB(36'h111111111, 1'b1, 1'b1, "R6 mailbox1 read");
    repeat (4) @(negedge clkA);
    check("R6 flag1 released after real read", {35'd0, mail1FullN}, 36'd1);

    // R5 + R8 on mailbox 2
    writeB(36'h333333333, 1'b1);
    writeB(36'h444444444, 1'b1);
    repeat (4) @(negedge clkA);
    readA(36'h333333333, 1'b0, 1'b1, "R5 mailbox2 kept, R8 fifo read");
    repeat (6) @(negedge clkB);
    check("R8 flag2 kept by fifo read", {35'd0, mail2FullN}, 36'd0);
    readA(36'h333333333, 1'b1, 1'b0, "R5 mailbox2 kept, R8 no enable");
    repeat (6) @(negedge clkB);
    check("R8 flag2 kept without enable", {35'd0, mail2FullN}, 36'd0);
    readA(36'h333333333, 1'b1, 1'b1, "R7 mailbox2 read");
    repeat (4) @(negedge clkB);
    check("R7 flag2 released after real read", {35'd0, mail2FullN}, 36'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule